// File: doc/BRIEF.md
# Two-Wire Serial Bus Slave

This block is a target device on a two-wire serial bus whose data line is open-drain. A fast system clock samples the bus clock and data line. The block finds START, repeated START and STOP conditions and takes in a control byte. It answers only when that byte carries the fixed prefix `1001` and three low address bits that match the strap inputs. Up to eight such slaves can therefore share one pair of wires. The block never drives the data line high. It either pulls the line low or leaves it alone.

On the user side, the block offers a byte-wide register port. In a write transfer, the first byte after the control byte is a command or pointer byte and is presented on its own output. Each later byte comes out with a one-cycle write strobe. In a read transfer, the block pulls each outgoing byte from the user with a one-cycle read strobe. It then shifts that byte out, most significant bit first, until the master refuses a byte. The system clock must run at least eight times faster than the bus clock.

Top module: `twowire_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0), all strobes are low and `cmd_o` and `wr_data_o` read zero.
- R2: The control byte is taken in MSB first. A match needs bits 7..4 = `1001` and bits 3..1 = `strap_i[2:0]` (bit 3 against `strap_i[2]`). Bit 0 selects the direction: 1 = read, 0 = write. On a match the slave holds the data line low for the whole ninth clock.
- R3: On a mismatch the slave does not acknowledge that byte or any later byte. It drives nothing and raises no strobe until the next START.
- R4: The first byte after a matched write control byte is acknowledged. It appears on `cmd_o` with a one-cycle `cmd_stb`, and `cmd_o` keeps it until the next command byte.
- R5: Each further byte of a write transfer is acknowledged. It appears on `wr_data_o` with a one-cycle `wr_stb`, in arrival order.
- R6: In a read, `rd_stb` is high for one cycle. It comes in the system cycle after the falling edge of the acknowledge clock is seen. The byte on `rd_data_i` in that cycle is shifted out MSB first. `sda_oe` changes only while the bus clock is low.
- R7: When the master acknowledges a read byte, the next byte is requested and sent. When the master does not acknowledge, the slave releases the line and raises no further `rd_stb` until a new START.
- R8: A repeated START anywhere in a transfer makes the next byte a fresh control byte, with no STOP or idle bus needed.
- R9: A STOP anywhere in a transfer clears the byte framing. A partly received byte is dropped with no strobe, and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level as sensed at the pad |
| sda_i | input | 1 | Bus data level as sensed at the pad |
| strap_i | input | 3 | Low three address bits from strap pins |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| cmd_o | output | 8 | Last command/pointer byte received |
| cmd_stb | output | 1 | One-cycle pulse when `cmd_o` is updated |
| wr_data_o | output | 8 | Last write data byte received |
| wr_stb | output | 1 | One-cycle pulse when `wr_data_o` is updated |
| rd_stb | output | 1 | One-cycle request for the next read byte |
| rd_data_i | input | 8 | Read byte, sampled in the `rd_stb` cycle |

## Verification
Two events can land inside the same short low phase of the bus clock. One is the slave letting go of the data line after its acknowledge (or after a master NACK). The other is the master's first data move of a repeated START, or of a STOP. If the synchronizer order slipped, the slave's own release could be read as a bus condition, or a bus condition could be missed. The bench provokes this by running repeated STARTs and STOPs straight after acknowledge clocks, with the quarter-period drawn at random down to the minimum clock ratio. It judges the result by whether the following control byte is acknowledged and by exact strobe counts against a bench model.

// File: rtl/twowire_slave.sv
module twowire_slave #(
  parameter logic [3:0] ADDR_PREFIX = 4'b1001,
  parameter int         SYNC        = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe,
  output logic [7:0] cmd_o,
  output logic       cmd_stb,
  output logic [7:0] wr_data_o,
  output logic       wr_stb,
  output logic       rd_stb,
  input  logic [7:0] rd_data_i
);
  localparam logic [3:0] LAST = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_RXB, S_ACK, S_LOAD, S_TXB, S_TACK} st_t;

  st_t             st;
  logic [SYNC-1:0] scl_sy, sda_sy;
  logic            scl_q, sda_q, scl_d, sda_d;
  logic            scl_rise, scl_fall, start_det, stop_det;
  logic [3:0]      cnt;
  logic [7:0]      sr, txsr;
  logic            is_addr, rw, first, mack;
  logic            addr_hit;

  assign scl_q     = scl_sy[SYNC-1];
  assign sda_q     = sda_sy[SYNC-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
  assign addr_hit  = (sr[7:4] == ADDR_PREFIX) && (sr[3:1] == strap_i);

  assign sda_oe = (st == S_ACK) | ((st == S_TXB) & ~txsr[7]);
  assign rd_stb = (st == S_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy    <= '1;
      sda_sy    <= '1;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      st        <= S_IDLE;
      cnt       <= '0;
      sr        <= '0;
      txsr      <= '1;
      is_addr   <= 1'b0;
      rw        <= 1'b0;
      first     <= 1'b0;
      mack      <= 1'b0;
      cmd_o     <= '0;
      cmd_stb   <= 1'b0;
      wr_data_o <= '0;
      wr_stb    <= 1'b0;
    end else begin
      scl_sy  <= {scl_sy[SYNC-2:0], scl_i};
      sda_sy  <= {sda_sy[SYNC-2:0], sda_i};
      scl_d   <= scl_q;
      sda_d   <= sda_q;
      cmd_stb <= 1'b0;
      wr_stb  <= 1'b0;
      if (start_det) begin
        st      <= S_RXB;
        cnt     <= '0;
        is_addr <= 1'b1;
      end else if (stop_det) begin
        st <= S_IDLE;
      end else begin
        unique case (st)
          S_IDLE: ;
          S_RXB: begin
            if (scl_rise) begin
              sr  <= {sr[6:0], sda_q};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == LAST) begin
              if (is_addr) begin
                if (addr_hit) begin
                  st    <= S_ACK;
                  rw    <= sr[0];
                  first <= 1'b1;
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                st <= S_ACK;
                if (first) begin
                  cmd_o   <= sr;
                  cmd_stb <= 1'b1;
                  first   <= 1'b0;
                end else begin
                  wr_data_o <= sr;
                  wr_stb    <= 1'b1;
                end
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              is_addr <= 1'b0;
              cnt     <= '0;
              st      <= (is_addr && rw) ? S_LOAD : S_RXB;
            end
          end
          S_LOAD: begin
            txsr <= rd_data_i;
            cnt  <= '0;
            st   <= S_TXB;
          end
          S_TXB: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == LAST) st <= S_TACK;
              else txsr <= {txsr[6:0], 1'b1};
            end
          end
          S_TACK: begin
            if (scl_rise) mack <= ~sda_q;
            else if (scl_fall) st <= mack ? S_LOAD : S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module twowire_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_q,
  input logic scl_d,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic cmd_stb,
  input logic wr_stb,
  input logic rd_stb
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!sda_oe && !cmd_stb && !wr_stb && !rd_stb)); // R1
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb); // R4
  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_stb && wr_stb)); // R4
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R5
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb); // R6
  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && scl_d) |-> $stable(sda_oe)); // R6
  AST_RESTART_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && !rd_stb)); // R8
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && !rd_stb && !wr_stb && !cmd_stb)); // R9
endmodule

bind twowire_slave twowire_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_q    (scl_q),
  .scl_d    (scl_d),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_oe   (sda_oe),
  .cmd_stb  (cmd_stb),
  .wr_stb   (wr_stb),
  .rd_stb   (rd_stb)
);

// File: tb/twowire_slave_bench.sv
module twowire_slave_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_low = 1'b0;
  logic [2:0] strap = 3'd5;
  logic       sda_oe, cmd_stb, wr_stb, rd_stb;
  logic [7:0] cmd_o, wr_data_o, rd_data;
  logic       sda_line;

  int checks = 0, fails = 0;
  int q = 4;
  int rd_seen = 0, wr_n = 0, cmd_n = 0, hi_moves = 0;
  logic [7:0] wr_log [0:1023];
  logic [7:0] model_cmd = 8'h00;
  logic oe_prev = 1'b0, scl_prev = 1'b1;

  always #4 clk = ~clk;

  assign sda_line = ~(sda_low | sda_oe);

  function automatic logic [7:0] rd_pat(logic [7:0] p, int n);
    logic [7:0] nn = 8'(n);
    return (p * 8'd29 + nn * 8'd83) ^ 8'hC3;
  endfunction

  function automatic bit hit(logic [6:0] a7, logic [2:0] s);
    return (a7[6:3] == 4'b1001) && (a7[2:0] == s);
  endfunction

  assign rd_data = rd_pat(cmd_o, rd_seen);

  twowire_slave u_twowire_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
    .sda_oe(sda_oe), .cmd_o(cmd_o), .cmd_stb(cmd_stb), .wr_data_o(wr_data_o),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_data_i(rd_data)
  );

  always @(negedge clk) begin
    if (rd_stb) rd_seen++;
    if (cmd_stb) cmd_n++;
    if (wr_stb) begin
      wr_log[wr_n % 1024] = wr_data_o;
      wr_n++;
    end
    if (rst_n && scl_m && scl_prev && sda_oe != oe_prev) hi_moves++;
    oe_prev  = sda_oe;
    scl_prev = scl_m;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    sda_low = 1'b0; w(q);
    scl_m = 1'b1;   w(q);
    sda_low = 1'b1; w(q);
    scl_m = 1'b0;   w(q);
  endtask

  task automatic m_stop;
    sda_low = 1'b1; w(q);
    scl_m = 1'b1;   w(q);
    sda_low = 1'b0; w(q);
  endtask

  task automatic m_bits(logic [7:0] b, int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_low = ~b[i]; w(q);
      scl_m = 1'b1;    w(q);
      scl_m = 1'b0;    w(q);
    end
  endtask

  task automatic m_wbyte(input logic [7:0] b, output bit ack);
    bit a1;
    m_bits(b, 8);
    sda_low = 1'b0; w(q);
    scl_m = 1'b1; w(1);
    a1 = ~sda_line; w(q - 1);
    ack = a1 & ~sda_line;
    scl_m = 1'b0; w(q);
  endtask

  task automatic m_rbyte(input bit mack, output logic [7:0] b);
    sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      w(q);
      scl_m = 1'b1; w(q);
      b[i] = sda_line;
      scl_m = 1'b0; w(q);
    end
    sda_low = mack; w(q);
    scl_m = 1'b1;   w(q);
    scl_m = 1'b0;   w(q);
  endtask

  task automatic txn_write(logic [6:0] a7, int n, bit do_stop);
    bit ack, m;
    logic [7:0] dat [0:7];
    int base, cbase;
    m = hit(a7, strap);
    base = wr_n; cbase = cmd_n;
    m_start;
    m_wbyte({a7, 1'b0}, ack);
    chk(ack == m, m ? "R2" : "R3", "address ack", ack, m);
    for (int i = 0; i < n; i++) begin
      dat[i] = 8'($urandom);
      m_wbyte(dat[i], ack);
      chk(ack == m, m ? (i == 0 ? "R4" : "R5") : "R3", "data ack", ack, m);
    end
    if (m) begin
      if (n > 0) model_cmd = dat[0];
      chk(cmd_n == cbase + (n > 0 ? 1 : 0), "R4", "cmd strobes", cmd_n - cbase, n > 0);
      chk(cmd_o == model_cmd, "R4", "cmd value", cmd_o, model_cmd);
      chk(wr_n == base + (n > 1 ? n - 1 : 0), "R5", "write strobes", wr_n - base, n > 1 ? n - 1 : 0);
      for (int i = 1; i < n; i++)
        chk(wr_log[(base + i - 1) % 1024] == dat[i], "R5", "write byte", wr_log[(base + i - 1) % 1024], dat[i]);
    end else begin
      chk(wr_n == base && cmd_n == cbase, "R3", "strobes on mismatch", wr_n - base + cmd_n - cbase, 0);
    end
    if (do_stop) m_stop;
  endtask

  task automatic txn_read(logic [6:0] a7, int n, bit extra);
    bit ack, m;
    logic [7:0] b;
    int rbase;
    m = hit(a7, strap);
    rbase = rd_seen;
    m_start;
    m_wbyte({a7, 1'b1}, ack);
    chk(ack == m, m ? "R8" : "R3", "read address ack", ack, m);
    for (int i = 0; i < n; i++) begin
      m_rbyte(i < n - 1, b);
      if (m) chk(b == rd_pat(model_cmd, rbase + i + 1), "R6", "read byte", b, rd_pat(model_cmd, rbase + i + 1));
      else   chk(b == 8'hFF, "R3", "read byte on mismatch", b, 8'hFF);
    end
    chk(rd_seen == rbase + (m ? n : 0), "R7", "read strobes", rd_seen - rbase, m ? n : 0);
    if (extra) begin
      m_rbyte(1'b1, b);
      chk(b == 8'hFF, "R7", "line after NACK", b, 8'hFF);
      chk(rd_seen == rbase + (m ? n : 0), "R7", "strobes after NACK", rd_seen - rbase, m ? n : 0);
    end
    m_stop;
  endtask

  initial begin
    bit ack;
    int base;
    void'($urandom(32'd2024));
    w(3);
    chk(sda_oe == 0 && cmd_stb == 0 && wr_stb == 0 && rd_stb == 0, "R1", "outputs in reset", sda_oe, 0);
    rst_n = 1'b1;
    w(3);
    chk(cmd_o == 8'h00 && wr_data_o == 8'h00 && sda_oe == 0, "R1", "values after reset", {cmd_o, wr_data_o}, 0);

    txn_write({4'b1001, 3'd5}, 4, 1'b1);
    for (int s = 0; s < 8; s++) txn_write({4'b1001, 3'(s)}, 2, 1'b1);
    txn_write({4'b1101, 3'd5}, 2, 1'b1);

    txn_write({4'b1001, 3'd5}, 1, 1'b0);
    txn_read({4'b1001, 3'd5}, 3, 1'b1);

    txn_write({4'b0001, 3'd5}, 1, 1'b0);
    txn_read({4'b1001, 3'd5}, 2, 1'b0);

    base = wr_n;
    m_start;
    m_wbyte({4'b1001, 3'd5, 1'b0}, ack);
    m_wbyte(8'h3C, ack);
    model_cmd = 8'h3C;
    m_bits(8'hA5, 4);
    m_stop;
    w(2);
    chk(wr_n == base, "R9", "partial byte strobe", wr_n - base, 0);
    chk(sda_oe == 0, "R9", "released after stop", sda_oe, 0);
    txn_write({4'b1001, 3'd5}, 2, 1'b1);

    for (int it = 0; it < 40; it++) begin
      int kind, n;
      logic [6:0] a7;
      q = 3 + int'($urandom % 4);
      strap = 3'($urandom);
      kind = int'($urandom % 4);
      n = 1 + int'($urandom % 4);
      a7 = ($urandom % 3 == 0) ? 7'($urandom) : {4'b1001, strap};
      case (kind)
        0: txn_write(a7, n, 1'b1);
        1: txn_write(7'($urandom), n, 1'b1);
        2: begin
          txn_write({4'b1001, strap}, 1, 1'b0);
          txn_read(a7, n, 1'b0);
        end
        default: txn_read(a7, n, it[0]);
      endcase
    end
    w(4);
    chk(hi_moves == 0, "R6", "sda moves while scl high", hi_moves, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule